// File: doc/BRIEF.md
# Golomb-Rice parameter selector

This block chooses the Golomb-Rice parameter k for a group of four unsigned prediction residuals that will be coded together with one shared k. Each residual costs a unary quotient (e >> k) with a stop bit, followed by k plain remainder bits. The whole group therefore costs 4*(k+1) plus the sum of the four quotients. The block returns the k in the legal range 0..7 that gives the shortest group, and the length that k gives.

The four residuals are added once. The mean (sum >> 2) selects a window of three consecutive candidates: base, base+1 and base+2, where base is one less than the index of the top set bit of the mean, clamped into 0..5. A mean of zero gives base 0. Every candidate length is derived from the one shared sum. The low k bits of each residual are added up, that total is taken off the sum, and the difference is shifted right by k. This gives the exact quotient sum. Two magnitude comparators then pick the shortest of the three. The result is registered, so the answer for a group presented in one cycle appears in the next.

Top module: `gr_kparam_sel`

## Requirements
- R1: While rst_n is low, out_valid, out_k and out_len are all zero.
- R2: out_valid is high in exactly the cycle after a cycle where in_valid was high at the clock edge, so groups may arrive back to back, one per cycle.
- R3: Residual i (i = 0..3) is the unsigned 6-bit field res_flat[6*i+5 : 6*i]. For a valid group, out_len equals the minimum over k = 0..7 of 4*(k+1) + sum of (e_i >> k).
- R4: out_k is the smallest k in 0..7 that reaches the minimum length. For example, (1,1,1,1) gives out_k 0 and out_len 8, even though k = 1 also costs 8.
- R5: An all-zero group gives out_k 0 and out_len 4.
- R6: A group of four 63s gives out_k 5 and out_len 28, because the tie between k = 5 and k = 6 resolves to 5.
- R7: In a cycle where in_valid was low, out_valid drops to 0 and out_k and out_len keep their previous values, whatever res_flat carries.
- R8: The skewed group (63,0,0,0) gives out_k 3 and out_len 23, because the tie between k = 3 and k = 4 resolves to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | res_flat holds a group to be evaluated |
| res_flat | input | 24 | Four 6-bit unsigned residuals, sample i in bits 6*i+5..6*i |
| out_valid | output | 1 | out_k and out_len belong to the group of the previous cycle |
| out_k | output | 3 | Chosen Golomb-Rice parameter |
| out_len | output | 9 | Coded length of the group, in bits, for out_k |

## Verification
The bench checks every group against an exhaustive search over all eight k values. A design whose window is one position off would miss the optimum on groups whose mean sits at a power of two. A design that forgot the remainder correction would give lengths that are too long or too short whenever the low bits of the inputs carry into the upper bits of the sum. Ties are the sharpest corner: the all-63 group, the single-63 group and (1,1,1,1) each tie two parameters, so a comparator that uses less-or-equal would report the larger k. Two further checks cover output timing. A back-to-back stream catches a design that loses or delays groups. Idle cycles with changing data on res_flat catch a design whose outputs follow the inputs when in_valid is low.

// File: rtl/gr_pkg.sv
package gr_pkg;

    localparam int GR_N_SMP  = 4;
    localparam int GR_RES_W  = 6;
    localparam int GR_K_MAX  = 7;
    localparam int GR_N_CAND = 3;

    // Index of the highest set bit, -1 for a zero argument.
    function automatic int top_bit(input logic [31:0] v);
        int p;
        p = -1;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) p = b;
        end
        return p;
    endfunction

endpackage

// File: rtl/gr_region.sv
module gr_region #(
    parameter int N_SMP  = gr_pkg::GR_N_SMP,
    parameter int RES_W  = gr_pkg::GR_RES_W,
    parameter int K_MAX  = gr_pkg::GR_K_MAX,
    parameter int N_CAND = gr_pkg::GR_N_CAND,
    localparam int SUM_W = RES_W + $clog2(N_SMP),
    localparam int K_W   = $clog2(K_MAX + 1)
) (
    input  logic [N_SMP*RES_W-1:0] res_flat,
    output logic [SUM_W-1:0]       sum,
    output logic [K_W-1:0]         base
);
    localparam int MEAN_SH  = $clog2(N_SMP);
    localparam int BASE_TOP = K_MAX - (N_CAND - 1);

    logic [SUM_W-1:0] mean;
    int               msb;
    int               b_raw;

    // Single shared adder over all samples.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N_SMP; i++) begin
            sum = sum + SUM_W'(res_flat[i*RES_W +: RES_W]);
        end
    end

    // Window start from the magnitude of the mean.
    always_comb begin
        mean  = sum >> MEAN_SH;
        msb   = gr_pkg::top_bit(32'(mean));
        b_raw = (msb >= 1) ? msb - 1 : 0;
        if (b_raw > BASE_TOP) b_raw = BASE_TOP;
        base  = K_W'(b_raw);
    end

endmodule

// File: rtl/gr_cand.sv
module gr_cand #(
    parameter int N_SMP  = gr_pkg::GR_N_SMP,
    parameter int RES_W  = gr_pkg::GR_RES_W,
    parameter int K_MAX  = gr_pkg::GR_K_MAX,
    localparam int SUM_W = RES_W + $clog2(N_SMP),
    localparam int K_W   = $clog2(K_MAX + 1),
    localparam int LEN_W = $clog2(N_SMP * (2**RES_W - 1) + N_SMP + 1)
) (
    input  logic [N_SMP*RES_W-1:0] res_flat,
    input  logic [SUM_W-1:0]       sum,
    input  logic [K_W-1:0]         k,
    output logic [LEN_W-1:0]       len
);
    logic [RES_W-1:0] mask;
    logic [SUM_W-1:0] rem_sum;
    logic [SUM_W-1:0] quot;

    // Remainders taken off the shared sum make the shift exact.
    always_comb begin
        mask    = RES_W'((32'd1 << k) - 32'd1);
        rem_sum = '0;
        for (int i = 0; i < N_SMP; i++) begin
            rem_sum = rem_sum + SUM_W'(res_flat[i*RES_W +: RES_W] & mask);
        end
        quot = (sum - rem_sum) >> k;
        len  = LEN_W'(N_SMP) * (LEN_W'(k) + LEN_W'(1)) + LEN_W'(quot);
    end

endmodule

// File: rtl/gr_pick.sv
module gr_pick #(
    parameter int K_MAX  = gr_pkg::GR_K_MAX,
    parameter int N_CAND = gr_pkg::GR_N_CAND,
    parameter int LEN_W  = 9,
    localparam int K_W   = $clog2(K_MAX + 1)
) (
    input  logic [N_CAND*LEN_W-1:0] lens_flat,
    input  logic [K_W-1:0]          base,
    output logic [K_W-1:0]          k,
    output logic [LEN_W-1:0]        len
);
    int best_j;

    // Strict less-than: the lower candidate wins on equal lengths.
    always_comb begin
        len    = lens_flat[LEN_W-1:0];
        best_j = 0;
        for (int j = 1; j < N_CAND; j++) begin
            if (lens_flat[j*LEN_W +: LEN_W] < len) begin
                len    = lens_flat[j*LEN_W +: LEN_W];
                best_j = j;
            end
        end
        k = base + K_W'(best_j);
    end

endmodule

// File: rtl/gr_kparam_sel.sv
module gr_kparam_sel #(
    parameter int N_SMP  = gr_pkg::GR_N_SMP,
    parameter int RES_W  = gr_pkg::GR_RES_W,
    parameter int K_MAX  = gr_pkg::GR_K_MAX,
    parameter int N_CAND = gr_pkg::GR_N_CAND,
    localparam int SUM_W = RES_W + $clog2(N_SMP),
    localparam int K_W   = $clog2(K_MAX + 1),
    localparam int LEN_W = $clog2(N_SMP * (2**RES_W - 1) + N_SMP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N_SMP*RES_W-1:0] res_flat,
    output logic                   out_valid,
    output logic [K_W-1:0]         out_k,
    output logic [LEN_W-1:0]       out_len
);
    typedef struct packed {
        logic             vld;
        logic [K_W-1:0]   k;
        logic [LEN_W-1:0] len;
    } sel_state_t;

    logic [SUM_W-1:0]        sum;
    logic [K_W-1:0]          base;
    logic [N_CAND*LEN_W-1:0] lens_flat;
    logic [K_W-1:0]          pick_k;
    logic [LEN_W-1:0]        pick_len;
    sel_state_t              st_d, st_q;

    gr_region #(
        .N_SMP(N_SMP), .RES_W(RES_W), .K_MAX(K_MAX), .N_CAND(N_CAND)
    ) u_region (
        .res_flat(res_flat),
        .sum     (sum),
        .base    (base)
    );

    for (genvar j = 0; j < N_CAND; j++) begin : g_cand
        logic [K_W-1:0] cand_k;
        assign cand_k = base + K_W'(j);
        gr_cand #(
            .N_SMP(N_SMP), .RES_W(RES_W), .K_MAX(K_MAX)
        ) u_cand (
            .res_flat(res_flat),
            .sum     (sum),
            .k       (cand_k),
            .len     (lens_flat[j*LEN_W +: LEN_W])
        );
    end

    gr_pick #(
        .K_MAX(K_MAX), .N_CAND(N_CAND), .LEN_W(LEN_W)
    ) u_pick (
        .lens_flat(lens_flat),
        .base     (base),
        .k        (pick_k),
        .len      (pick_len)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.k   = pick_k;
            st_d.len = pick_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_k     = st_q.k;
    assign out_len   = st_q.len;

endmodule

// File: rtl/gr_kparam_sel_chk.sv
module gr_kparam_sel_chk #(
    parameter int N_SMP  = 4,
    parameter int RES_W  = 6,
    parameter int K_W    = 3,
    parameter int LEN_W  = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [N_SMP*RES_W-1:0] res_flat,
    input logic                   out_valid,
    input logic [K_W-1:0]         out_k,
    input logic [LEN_W-1:0]       out_len
);
    logic [15:0] in_sum;

    always_comb begin
        in_sum = '0;
        for (int i = 0; i < N_SMP; i++) begin
            in_sum = in_sum + 16'(res_flat[i*RES_W +: RES_W]);
        end
    end

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_k == '0 && out_len == '0));

    // R2: valid follows one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: idle cycle holds result and drops valid
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_k) && $stable(out_len)));

    // R3: never longer than the k = 0 code of the same group
    a_r3_len_upper: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (16'(out_len) <= $past(in_sum) + 16'(N_SMP)));

    // R3: never shorter than the fixed part of the chosen k
    a_r3_len_lower: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (16'(out_len) >= 16'(N_SMP) * (16'(out_k) + 16'd1)));

endmodule

bind gr_kparam_sel gr_kparam_sel_chk #(
    .N_SMP(N_SMP), .RES_W(RES_W), .K_W(K_W), .LEN_W(LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .res_flat (res_flat),
    .out_valid(out_valid),
    .out_k    (out_k),
    .out_len  (out_len)
);

// File: tb/sim_gr_kparam_sel.sv
module sim_gr_kparam_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] res_flat = '0;
    logic        out_valid;
    logic [2:0]  out_k;
    logic [8:0]  out_len;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gr_kparam_sel u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_flat(res_flat),
        .out_valid(out_valid), .out_k(out_k), .out_len(out_len)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Exhaustive search, smallest k kept on ties.
    task automatic ref_pick(input int a, input int b, input int c, input int d,
                            output int bk, output int bl);
        bl = 1 << 30;
        bk = 0;
        for (int k = 0; k < 8; k++) begin
            int l;
            l = 4 * (k + 1) + (a >> k) + (b >> k) + (c >> k) + (d >> k);
            if (l < bl) begin
                bl = l;
                bk = k;
            end
        end
    endtask

    function automatic logic [23:0] pack4(input int a, input int b, input int c, input int d);
        return {6'(d), 6'(c), 6'(b), 6'(a)};
    endfunction

    // One group, outputs read at the following falling edge.
    task automatic run_group(input int a, input int b, input int c, input int d,
                             input string tag);
        int ek, el;
        ref_pick(a, b, c, d, ek, el);
        @(negedge clk);
        res_flat = pack4(a, b, c, d);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 valid"}, int'(out_valid), 1);
        chk({tag, " R3 len"}, int'(out_len), el);
        chk({tag, " R4 k"}, int'(out_k), ek);
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        res_flat = pack4(40, 5, 17, 63);
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 k in reset", int'(out_k), 0);
        chk("R1 len in reset", int'(out_len), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fixed_corners();
        run_group(0, 0, 0, 0, "R5 zero");
        chk("R5 zero k", int'(out_k), 0);
        chk("R5 zero len", int'(out_len), 4);
        run_group(63, 63, 63, 63, "R6 max");
        chk("R6 max k", int'(out_k), 5);
        chk("R6 max len", int'(out_len), 28);
        run_group(63, 0, 0, 0, "R8 skew");
        chk("R8 skew k", int'(out_k), 3);
        chk("R8 skew len", int'(out_len), 23);
        run_group(1, 1, 1, 1, "R4 tie");
        chk("R4 tie k", int'(out_k), 0);
        chk("R4 tie len", int'(out_len), 8);
    endtask

    task automatic t_sweeps();
        for (int v = 0; v < 64; v++) begin
            run_group(v, v, v, v, "R3 flat sweep");
            run_group(0, 0, v, 0, "R3 single sweep");
            run_group(v, 63 - v, v >> 1, 1, "R3 mixed sweep");
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            int sh;
            sh = $urandom_range(0, 5);
            run_group(int'($urandom_range(0, 63)) >> sh, int'($urandom_range(0, 63)) >> sh,
                      int'($urandom_range(0, 63)) >> sh, int'($urandom_range(0, 63)),
                      "R3 random");
        end
    endtask

    task automatic t_stream();
        int pk, pl, ek, el;
        pk = 0;
        pl = 0;
        for (int n = 0; n <= 16; n++) begin
            @(negedge clk);
            if (n > 0) begin
                chk("R2 stream valid", int'(out_valid), 1);
                chk("R3 stream len", int'(out_len), pl);
                chk("R4 stream k", int'(out_k), pk);
            end
            if (n < 16) begin
                int a, b, c, d;
                a = 4 * n; b = 63 - 3 * n; c = n; d = (n * 37) % 64;
                ref_pick(a, b, c, d, ek, el);
                pk = ek;
                pl = el;
                res_flat = pack4(a, b, c, d);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 stream ends", int'(out_valid), 0);
    endtask

    task automatic t_hold();
        int hk, hl;
        run_group(10, 20, 30, 40, "R7 setup");
        hk = int'(out_k);
        hl = int'(out_len);
        for (int n = 0; n < 5; n++) begin
            res_flat = pack4(63, 63, n, 0);
            @(negedge clk);
            chk("R7 idle valid", int'(out_valid), 0);
            chk("R7 idle k", int'(out_k), hk);
            chk("R7 idle len", int'(out_len), hl);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_fixed_corners();
        t_sweeps();
        t_random();
        t_stream();
        t_hold();
        finish_run();
    end

endmodule